// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Strobe Timer

This block shapes the read and write strobes of one parallel ATA host channel group for PIO and multiword DMA cycles. Each drive position has its own 32-bit timing word, written through a small configuration port. The word packs two timing sets: one for data cycles and one for task-file register cycles. Each set has a setup count, an active count and a recovery count, and each count is stored as the number of clocks minus one.

A transfer is started by a one-clock request that carries a channel number, a drive number, a register-versus-data select and a direction bit. The block copies the selected timing set, waits out the setup phase, and drives the active-low read or write strobe for the active count. It then holds the strobe inactive for the recovery count and pulses `done`. For reads, the bus data is captured on the clock at which the read strobe deasserts.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset, `dior_n` and `diow_n` are high, `done` is low and `rdata` is zero.
- R2: For a data cycle (`req_reg`=0), the strobe stays low for (word[8:4] + 1) clocks.
- R3: For a data cycle, the strobe stays high for (word[3:0] + 1) clocks after it rises, and `done` follows on the next clock.
- R4: For a data cycle, the strobe falls (word[24:22] + 1) clocks after the clock edge that accepts the request.
- R5: For a register cycle (`req_reg`=1), setup, active and recovery last (word[27:25] + 1), (word[17:13] + 1) and (word[12:9] + 1) clocks, and the data fields have no effect.
- R6: With `req_write`=1 only `diow_n` pulses. With `req_write`=0 only `dior_n` pulses. The two strobes are never low together.
- R7: The timing word used is the one stored at index `req_drive` + 2 * `req_chan`, which is written through `cfg_sel`. The four indexes hold independent words.
- R8: The timing word is copied when a request is accepted. A configuration write during a cycle changes only the following cycles.
- R9: `done` is high for exactly one clock. A request is accepted only while idle, at the earliest on the clock after `done`. A request raised during a cycle is ignored.
- R10: On a read, `rdata` takes the value of `bus_din` at the clock edge on which `dior_n` rises. `rdata` holds that value through write cycles.
- R11: Word bits 21:18 and 31:28 have no effect on strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for a timing word |
| cfg_sel | input | SEL_W | Timing word index (drive + 2 * channel) |
| cfg_word | input | 32 | Timing word to store |
| req | input | 1 | Start a cycle; sampled only while idle |
| req_chan | input | CH_W | Channel of the request |
| req_drive | input | 1 | Drive position within the channel |
| req_reg | input | 1 | 1 = task-file register timing, 0 = data timing |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| bus_din | input | DATA_W | Data read from the ATA bus |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse at the end of recovery |
| rdata | output | DATA_W | Data captured at the end of a read strobe |

## Verification
The embedded checks assume that `bus_din` is stable while the read strobe is low and at the clock where it rises. They also assume that a request names an existing channel. The stimulus changes `bus_din` and the request fields only between cycles, on the falling clock edge, and uses only channels 0 and 1. Configuration writes are allowed at any time, and one test deliberately writes during a cycle to show that the copy taken at acceptance governs the cycle.

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer #(
  parameter int CHANNELS = 2,
  parameter int DATA_W   = 16,
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int SEL_W   = CH_W + 1,
  localparam int DRIVES  = 2 * CHANNELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_word,
  input  logic              req,
  input  logic [CH_W-1:0]   req_chan,
  input  logic              req_drive,
  input  logic              req_reg,
  input  logic              req_write,
  input  logic [DATA_W-1:0] bus_din,
  output logic              dior_n,
  output logic              diow_n,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  typedef enum logic [2:0] {IDLE, SETUP, ACTIVE, RECOVER, FINISH} phase_t;

  // stored: {reg_setup[5:3] data_setup[2:0]} in [23:18], timing fields in [17:0]
  logic [23:0] twords [DRIVES];
  wire  unused_cfg_bits = ^{cfg_word[31:28], cfg_word[21:18]};

  phase_t     phase;
  logic [4:0] cnt, act_len;
  logic [3:0] rec_len;
  logic       is_write;

  wire [SEL_W-1:0] req_sel = {req_chan, req_drive};
  wire [23:0]      pick    = twords[req_sel];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DRIVES; i++) twords[i] <= '0;
    end else if (cfg_we) begin
      twords[cfg_sel] <= {cfg_word[27:22], cfg_word[17:0]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase    <= IDLE;
      cnt      <= '0;
      act_len  <= '0;
      rec_len  <= '0;
      is_write <= 1'b0;
      rdata    <= '0;
    end else begin
      unique case (phase)
        IDLE: if (req) begin
          phase    <= SETUP;
          is_write <= req_write;
          if (req_reg) begin
            cnt     <= {2'b0, pick[23:21]};
            act_len <= pick[17:13];
            rec_len <= pick[12:9];
          end else begin
            cnt     <= {2'b0, pick[20:18]};
            act_len <= pick[8:4];
            rec_len <= pick[3:0];
          end
        end
        SETUP:
          if (cnt == 0) begin
            phase <= ACTIVE;
            cnt   <= act_len;
          end else cnt <= cnt - 5'd1;
        ACTIVE:
          if (cnt == 0) begin
            phase <= RECOVER;
            cnt   <= {1'b0, rec_len};
            if (!is_write) rdata <= bus_din;
          end else cnt <= cnt - 5'd1;
        RECOVER:
          if (cnt == 0) phase <= FINISH;
          else cnt <= cnt - 5'd1;
        FINISH: phase <= IDLE;
        default: phase <= IDLE;
      endcase
    end

  assign dior_n = !(phase == ACTIVE && !is_write);
  assign diow_n = !(phase == ACTIVE &&  is_write);
  assign done   = (phase == FINISH);

  // checks
  logic [5:0] low_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_run <= '0;
    else if (!dior_n || !diow_n) low_run <= low_run + 6'd1;
    else low_run <= '0;

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dior_n || diow_n);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (dior_n && diow_n));
  assert_read_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dior_n) |-> rdata == $past(bus_din));
  assert_active_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dior_n) || $rose(diow_n)) |-> low_run == {1'b0, act_len} + 6'd1);
  assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != IDLE && $past(phase) != IDLE) |-> ($stable(act_len) && $stable(rec_len)));

endmodule

// File: tb/ata_strobe_timer_test.sv
`timescale 1ns/1ps
module ata_strobe_timer_test;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_word = 0;
  logic req = 0, req_chan = 0, req_drive = 0, req_reg = 0, req_write = 0;
  logic [DW-1:0] bus_din = 0;
  logic dior_n, diow_n, done;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] last_rd = 0;

  always #2 clk = ~clk;

  ata_strobe_timer uut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_word, .req,
    .req_chan, .req_drive, .req_reg, .req_write, .bus_din,
    .dior_n, .diow_n, .done, .rdata);

  // {word, 4'b0, ch, dr, reg, write}
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {32'hF0BC0031, 8'b0000_0000},
    {32'h00000000, 8'b0000_0101},
    {32'h0600A5F0, 8'b0000_1010},
    {32'h0E03FE00, 8'b0000_1111},
    {32'h01C001FF, 8'b0000_1001},
    {32'h00400052, 8'b0000_0000}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [31:0] w);
    @(negedge clk); cfg_we = 1; cfg_sel = idx[1:0]; cfg_word = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic xfer(input int ch, input int dr, input bit rg, input bit wr,
                      input logic [31:0] w, input logic [DW-1:0] din, input string rq);
    int pre = 0, act = 0, rec = 0, ph = 0, guard = 0;
    bit bad = 0, lo;
    int ep = rg ? int'(w[27:25]) + 1 : int'(w[24:22]) + 1;
    int ea = rg ? int'(w[17:13]) + 1 : int'(w[8:4]) + 1;
    int er = rg ? int'(w[12:9])  + 1 : int'(w[3:0]) + 1;
    @(negedge clk);
    req = 1; req_chan = ch[0]; req_drive = dr[0]; req_reg = rg; req_write = wr; bus_din = din;
    @(negedge clk); req = 0;
    while (!done && guard < 300) begin
      lo = wr ? !diow_n : !dior_n;
      if (wr ? !dior_n : !diow_n) bad = 1;
      case (ph)
        0: if (lo) begin ph = 1; act = 1; end else pre++;
        1: if (lo) act++; else begin ph = 2; rec = 1; end
        default: begin rec++; if (lo) bad = 1; end
      endcase
      guard++;
      @(negedge clk);
    end
    check(pre == ep, {rq, " setup (R4/R5)"}, pre, ep);
    check(act == ea, {rq, " active (R2/R5)"}, act, ea);
    check(rec == er, {rq, " recovery (R3/R5)"}, rec, er);
    check(!bad, {rq, " strobe select R6"}, bad, 0);
    if (!wr) last_rd = din;
    check(rdata == last_rd, {rq, " rdata R10"}, rdata, last_rd);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog R9: actual %0d expected %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dior_n && diow_n, "R1 strobes", {dior_n, diow_n}, 3);
    check(!done, "R1 done", done, 0);
    check(rdata == 0, "R1 rdata", rdata, 0);
    rst_n = 1;

    // table: R2 R3 R4 R5 R6 R10 R11
    for (int i = 0; i < NV; i++) begin
      int ch = VEC[i][3], dr = VEC[i][2];
      cfg(dr + 2 * ch, VEC[i][39:8]);
      xfer(ch, dr, VEC[i][1], VEC[i][0], VEC[i][39:8], 16'hA500 + 16'(i), $sformatf("vec%0d", i));
    end

    // R7 independent words per index
    cfg(0, 32'h00000010); cfg(1, 32'h00400021);
    cfg(2, 32'h00800032); cfg(3, 32'h00C00043);
    xfer(0, 0, 0, 0, 32'h00000010, 16'h1111, "R7 idx0");
    xfer(0, 1, 0, 1, 32'h00400021, 16'h2222, "R7 idx1");
    xfer(1, 0, 0, 0, 32'h00800032, 16'h3333, "R7 idx2");
    xfer(1, 1, 0, 1, 32'h00C00043, 16'h4444, "R7 idx3");

    // R8 write during a cycle affects only the next
    cfg(0, 32'h00400042);
    fork
      xfer(0, 0, 0, 0, 32'h00400042, 16'h5A5A, "R8 old word");
      begin repeat (2) @(negedge clk); cfg(0, 32'h00000010); end
    join
    xfer(0, 0, 0, 0, 32'h00000010, 16'h6B6B, "R8 new word");

    // R9 request held high: next accept on the clock after done
    cfg(1, 32'h00400000);
    @(negedge clk); req = 1; req_chan = 0; req_drive = 1; req_reg = 0; req_write = 1;
    n = 0;
    while (!done && n < 100) begin n++; @(negedge clk); end
    @(negedge clk);
    check(!done && dior_n && diow_n, "R9 idle after done", done, 0);
    n = 0;
    while (diow_n && n < 100) begin n++; @(negedge clk); end
    check(n == 3, "R9 restart delay", n, 3);
    req = 0;
    while (!done) @(negedge clk);

    // R9 request during a cycle is ignored
    cfg(2, 32'h00400033);
    @(negedge clk); req = 1; req_chan = 1; req_drive = 0; req_write = 0; bus_din = 16'h7C7C;
    @(negedge clk); req = 0;
    while (dior_n) @(negedge clk);
    req = 1; @(negedge clk); req = 0;
    while (!done) @(negedge clk);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!dior_n || !diow_n || done) n++;
    end
    check(n == 0, "R9 busy request ignored", n, 0);
    check(rdata == 16'h7C7C, "R10 capture", rdata, 16'h7C7C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule